// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire serial bus (a clock line and a bidirectional data line). In front of it sits a 2048 x 8 byte array. A fast system clock samples both bus lines. The block drives the data line only by asserting an open-drain pull-down enable. It finds START and STOP conditions and checks the device byte. Three bits of the device byte act as the upper address bits of the array; they do not select a chip. The block then accepts a word address and write data, or it returns read data.

Write data first collects in a 16-entry page buffer, and each entry carries a valid flag. When the master sends STOP, an internal busy period starts. During that period the buffered bytes are committed to the array and the block does not respond to the bus. Reads start at the current address and step through the array while the master keeps acknowledging.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: Both bus lines pass through a two-flop synchronizer. START is data falling while clock is high, and STOP is data rising while clock is high. Data changes while clock is high are never taken as bits. With the block idle or out of reset, `sda_oe_o` is 0 (line released).
- R2: The block responds only when bits 7..4 of the device byte equal 4'b1010. For any other value it gives no acknowledge and ignores the bus until the next START or STOP.
- R3: Bits 3..1 of the device byte become address bits 10..8. The 8-bit word address that follows a write device byte becomes bits 7..0. Bit 0 of the device byte selects the operation: 1 is read, 0 is write.
- R4: Acknowledge means `sda_oe_o` = 1 during the ninth clock pulse. The block acknowledges an accepted device byte, the word address and every write data byte, and it raises the enable only while the clock is low.
- R5: Each write data byte goes into the page buffer at the index given by address bits 3..0. Those four bits then increment modulo 16, and bits 10..4 stay fixed. Bytes past the 16th overwrite earlier entries.
- R6: The array changes only after STOP. A START that arrives before STOP throws away every buffered byte.
- R7: A STOP that follows at least one buffered byte starts a busy period of BUSY_CYCLES clocks. During it the block gives no acknowledge and holds `sda_oe_o` at 0. A STOP with nothing buffered starts no busy period.
- R8: A read sends the byte at the current address, most significant bit first. A master acknowledge increments the full 11-bit address, which wraps at the end of the array, and starts the next byte. A master no-acknowledge or STOP releases the line.
- R9: After a write, the current address is the last written address plus one inside its page, so a read device byte with the same upper bits then returns that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench aims at page roll-over. It writes 18 bytes starting two entries before the end of a page. A design that carried the increment into bit 4, or that kept the first bytes instead of the last, would read back the wrong data. It also sends a repeated START in the middle of a write and then reads the same location. A design that committed on START, or kept stale buffer flags, would return the discarded value. The bench sends a device byte right after STOP and checks that no acknowledge comes, and it sends a bad device identifier followed by a valid-looking byte with no START in between. Random page writes of random length, each read back across page and array boundaries, check the address split and the read increment.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACK,
    ST_TX, ST_MACK, ST_WAIT, ST_BUSY
  } twm_state_e;

  localparam logic [3:0] DEV_ID = 4'b1010;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_o;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // clock must be high on both samples so a data edge racing a clock edge is not a condition
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/twm_page_buf.sv
module twm_page_buf #(
  parameter int IDX_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             any_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (we_i)  vld_q[widx_i] <= 1'b1;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
  assign any_o    = |vld_q;
endmodule

// File: rtl/twm_array.sv
module twm_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
  import twm_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int HI_W     = ADDR_W - 8;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int BCNT_W   = $clog2(BUSY_CYCLES + 1);

  twm_state_e        state_q, nxt_q;
  logic [2:0]        bit_cnt_q;
  logic              got8_q, mack_q, sda_oe_q;
  logic [7:0]        rx_q, tx_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [BCNT_W-1:0] busy_cnt_q;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic buf_we, buf_clr, buf_rvalid, buf_any;
  logic [7:0] buf_rdata, arr_rdata;
  logic busy, committing, arr_we, busy_last;
  logic [PAGE_W-1:0] commit_idx;
  logic rx_state;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  assign busy       = (state_q == ST_BUSY);
  assign busy_last  = busy && (busy_cnt_q == BCNT_W'(BUSY_CYCLES - 1));
  assign committing = busy && (busy_cnt_q < BCNT_W'(PAGE_LEN));
  assign commit_idx = busy_cnt_q[PAGE_W-1:0];
  assign arr_we     = committing && buf_rvalid;
  assign rx_state   = (state_q == ST_DEV) || (state_q == ST_WADDR) ||
                      (state_q == ST_WDATA);
  assign buf_we     = !busy && !start_ev && !stop_ev && scl_fall && got8_q &&
                      (state_q == ST_WDATA);
  assign buf_clr    = busy_last || (!busy && start_ev);

  twm_page_buf #(.IDX_W(PAGE_W), .DW(8)) u_buf (
    .clk_i, .rst_ni,
    .we_i(buf_we), .widx_i(cur_addr_q[PAGE_W-1:0]), .wdata_i(rx_q),
    .clr_i(buf_clr), .ridx_i(commit_idx),
    .rdata_o(buf_rdata), .rvalid_o(buf_rvalid), .any_o(buf_any)
  );

  twm_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk_i,
    .we_i(arr_we),
    .waddr_i({cur_addr_q[ADDR_W-1:PAGE_W], commit_idx}),
    .wdata_i(buf_rdata),
    .raddr_i(cur_addr_q),
    .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      bit_cnt_q  <= '0;
      got8_q     <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      rx_q       <= '0;
      tx_q       <= '0;
      cur_addr_q <= '0;
      busy_cnt_q <= '0;
    end else if (busy) begin
      // deaf to the bus until the commit window closes
      busy_cnt_q <= busy_cnt_q + 1'b1;
      if (busy_last) state_q <= ST_IDLE;
    end else if (start_ev) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      got8_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (stop_ev) begin
      sda_oe_q   <= 1'b0;
      busy_cnt_q <= '0;
      state_q    <= buf_any ? ST_BUSY : ST_IDLE;
    end else begin
      if (rx_state && scl_rise) begin
        rx_q      <= {rx_q[6:0], sda_s};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == 3'd7) got8_q <= 1'b1;
      end
      if (rx_state && scl_fall && got8_q) begin
        got8_q <= 1'b0;
        unique case (state_q)
          ST_DEV: begin
            if (rx_q[7:4] == DEV_ID) begin
              cur_addr_q[ADDR_W-1 -: HI_W] <= rx_q[HI_W:1];
              nxt_q    <= rx_q[0] ? ST_TX : ST_WADDR;
              state_q  <= ST_ACK;
              sda_oe_q <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end
          ST_WADDR: begin
            cur_addr_q[7:0] <= rx_q;
            nxt_q    <= ST_WDATA;
            state_q  <= ST_ACK;
            sda_oe_q <= 1'b1;
          end
          default: begin
            cur_addr_q[PAGE_W-1:0] <= cur_addr_q[PAGE_W-1:0] + 1'b1;
            nxt_q    <= ST_WDATA;
            state_q  <= ST_ACK;
            sda_oe_q <= 1'b1;
          end
        endcase
      end
      if (scl_fall) begin
        unique case (state_q)
          ST_ACK: begin
            state_q   <= nxt_q;
            bit_cnt_q <= '0;
            got8_q    <= 1'b0;
            if (nxt_q == ST_TX) begin
              tx_q     <= arr_rdata;
              sda_oe_q <= ~arr_rdata[7];
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
          ST_TX: begin
            if (bit_cnt_q == 3'd7) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_MACK;
            end else begin
              tx_q      <= {tx_q[6:0], 1'b0};
              sda_oe_q  <= ~tx_q[6];
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_MACK: begin
            if (mack_q) begin
              tx_q      <= arr_rdata;
              sda_oe_q  <= ~arr_rdata[7];
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
      if (state_q == ST_MACK && scl_rise) begin
        mack_q <= ~sda_s;
        if (!sda_s) cur_addr_q <= cur_addr_q + 1'b1;
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/twm_checker.sv
module twm_checker
  import twm_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 600,
  parameter int BCNT_W      = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_o,
  input logic              scl_fall,
  input twm_state_e        state_q,
  input logic [BCNT_W-1:0] busy_cnt_q,
  input logic [ADDR_W-1:0] cur_addr_q
);
  // R1
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o);

  // R2
  a_r2_wait_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !sda_oe_o);

  // R4
  a_r4_pull_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R5
  a_r5_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WDATA || state_q == ST_ACK) &&
     ($past(state_q) == ST_WDATA || $past(state_q) == ST_ACK))
    |-> $stable(cur_addr_q[ADDR_W-1:PAGE_W]));

  // R7
  a_r7_busy_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BUSY |-> !sda_oe_o);

  // R7
  a_r7_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q == ST_BUSY) |-> $past(busy_cnt_q) == BCNT_W'(BUSY_CYCLES - 1));
endmodule

bind twowire_eeprom_slave twm_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES), .BCNT_W(BCNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .scl_fall(scl_fall),
  .state_q(state_q), .busy_cnt_q(busy_cnt_q), .cur_addr_q(cur_addr_q)
);

// File: tb/twowire_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module twowire_eeprom_slave_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  logic [7:0] shadow [2048];
  bit         known  [2048];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twowire_eeprom_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    wt(2); sda_m = 1'b1; wt(H); scl = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    wt(2); sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic bus_bit(input bit m, output bit s);
    wt(3); sda_m = m; wt(H - 3); scl = 1'b1; wt(H / 2);
    s = sda_line; wt(H / 2); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~m_ack, s);
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] hi, input bit rd);
    return {4'b1010, hi, rd};
  endfunction

  // returns number of nacked polls before the slave answered
  task automatic poll_ready(output int polls);
    bit ack;
    polls = 0;
    ack = 1'b0;
    while (!ack && polls < 100) begin
      bus_start();
      send_byte(dev_byte(3'd0, 1'b0), ack);
      bus_stop();
      if (!ack) polls++;
    end
  endtask

  task automatic page_write(input logic [10:0] addr, input int n, input logic [7:0] d[32],
                            input string req);
    bit ack;
    int p;
    bus_start();
    send_byte(dev_byte(addr[10:8], 1'b0), ack);
    chk(ack, "R4 dev ack", ack, 1);
    send_byte(addr[7:0], ack);
    chk(ack, "R4 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack);
      chk(ack, req, ack, 1);
      shadow[{addr[10:4], 4'(addr[3:0] + i)}] = d[i];
      known[{addr[10:4], 4'(addr[3:0] + i)}]  = 1'b1;
    end
    bus_stop();
    poll_ready(p);
  endtask

  task automatic read_at(input logic [10:0] addr, input int n, input string req);
    bit ack;
    logic [7:0] b;
    logic [10:0] a;
    bus_start();
    send_byte(dev_byte(addr[10:8], 1'b0), ack);
    send_byte(addr[7:0], ack);
    bus_start();
    send_byte(dev_byte(addr[10:8], 1'b1), ack);
    chk(ack, "R3 read dev ack", ack, 1);
    a = addr;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      if (known[a]) chk(b === shadow[a], req, b, shadow[a]);
      a = a + 11'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    int polls;
    logic [7:0] b;
    logic [7:0] d[32];
    logic [10:0] a;
    int n;
    void'($urandom(32'h1c0d_e5ee));
    for (int i = 0; i < 2048; i++) known[i] = 1'b0;

    wt(5);
    chk(sda_oe == 1'b0, "R1 reset released", sda_oe, 0);
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe == 1'b0, "R1 idle released", sda_oe, 0);

    // R2: bad identifier, then a good-looking byte with no START in between
    bus_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R2 bad id nack", ack, 0);
    send_byte(8'hA0, ack);
    chk(!ack, "R2 ignored until start", ack, 0);
    bus_stop();

    // byte write at 0x325, then probe during busy
    bus_start();
    send_byte(dev_byte(3'd3, 1'b0), ack);
    chk(ack, "R4 dev ack", ack, 1);
    send_byte(8'h25, ack);
    chk(ack, "R4 addr ack", ack, 1);
    send_byte(8'h5C, ack);
    chk(ack, "R4 data ack", ack, 1);
    bus_stop();
    shadow[11'h325] = 8'h5C; known[11'h325] = 1'b1;
    bus_start();
    send_byte(dev_byte(3'd3, 1'b0), ack);
    chk(!ack, "R7 busy nack", ack, 0);
    chk(sda_oe == 1'b0, "R7 busy released", sda_oe, 0);
    bus_stop();
    poll_ready(polls);
    chk(polls > 0 && polls < 100, "R7 busy ends", polls, 1);

    // R3: same low byte, other upper bits
    d[0] = 8'h11;
    page_write(11'h525, 1, d, "R4 data ack");
    read_at(11'h325, 1, "R3 upper bits from device byte");
    read_at(11'h525, 1, "R3 upper bits from device byte");

    // R8: no-acknowledge releases the line
    bus_start();
    send_byte(dev_byte(3'd3, 1'b1), ack);
    recv_byte(1'b0, b);
    wt(4);
    chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
    bus_stop();

    // R5: 18 bytes from index 14 roll over inside page 0x14x
    for (int i = 0; i < 18; i++) d[i] = 8'h80 + 8'(i);
    page_write(11'h14E, 18, d, "R5 page data ack");
    // R9: current address is 0x140 now
    bus_start();
    send_byte(dev_byte(3'd1, 1'b1), ack);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == 8'h82, "R9 current address read", b, 8'h82);
    read_at(11'h140, 16, "R5 roll-over contents");

    // R6: repeated START throws away the buffered byte
    bus_start();
    send_byte(dev_byte(3'd1, 1'b0), ack);
    send_byte(8'h4E, ack);
    send_byte(8'hEE, ack);
    bus_start();
    bus_stop();
    bus_start();
    send_byte(dev_byte(3'd1, 1'b0), ack);
    chk(ack, "R7 no busy after empty stop", ack, 1);
    bus_stop();
    read_at(11'h14E, 1, "R6 discarded on start");

    // R8: sequential read wrapping the array end
    d[0] = 8'hA1; d[1] = 8'hB2;
    page_write(11'h7FF, 1, d, "R4 data ack");
    page_write(11'h000, 1, d[1:1] == d[1:1] ? '{default: 8'hB2} : d, "R4 data ack");
    read_at(11'h7FF, 2, "R8 read wraps address");

    // random page writes and read-backs
    for (int it = 0; it < 8; it++) begin
      a = 11'($urandom_range(0, 2047));
      n = $urandom_range(1, 20);
      for (int i = 0; i < 32; i++) d[i] = 8'($urandom);
      page_write(a, n, d, "R5 random data ack");
      read_at({a[10:4], 4'h0}, 17, "R8 random read-back");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule